// File: doc/BRIEF.md
# History-Correlated Branch Direction Predictor

This block guesses whether a conditional branch will be taken while the branch is still being fetched. It keeps a table of two-bit saturating counters with no tags. A fetch address picks one counter. The prediction is taken when that counter is in one of its two upper states. When a branch resolves in the execute stage, the pipeline sends back the branch address, the real outcome and the history value that was used for the prediction. The counter selected by those values then moves one step toward the outcome, and the outcome is shifted into a global history register.

A parameter picks how the table index is formed. In plain mode the index is a field of the branch address. In correlated mode that field is XORed with the global history, so one branch can use different counters depending on the path that led to it. The current history is driven out beside each prediction. Fetch keeps it with the branch and returns it on the update port. Two different branches that map to the same counter share it, and this aliasing is accepted.

Top module: `dirpred`

## Requirements
- R1: After a synchronous active-high reset, every counter holds weakly not-taken (value 1), so every lookup predicts not-taken, and the history output `lk_hist` is zero.
- R2: `lk_taken` is 1 exactly when the selected counter holds 2 or 3. Counter values are 0 strong not-taken, 1 weak not-taken, 2 weak taken and 3 strong taken.
- R3: A valid update with outcome taken raises the selected counter by one and saturates at 3.
- R4: A valid update with outcome not-taken lowers the selected counter by one and saturates at 0.
- R5: A counter at 3 still predicts taken after one not-taken update. It predicts not-taken only after a second consecutive not-taken update.
- R6: In plain mode the index is PC bits [9:2] (256 entries). Addresses that differ only in bits [1:0] or above bit 9 share a counter.
- R7: In correlated mode the index is PC bits [9:2] XOR the history, with the history zero-extended at the top. Lookups use the live history register. Updates use `up_hist`.
- R8: Each valid update shifts the outcome (1 = taken) into bit 0 of the history register. Older outcomes move toward the MSB and the oldest is dropped. The register value appears on `lk_hist`.
- R9: The counter that an update changes is chosen by `up_hist`, not by the history register as it stands at update time.
- R10: A lookup and an update to the same counter in the same cycle return the counter value from before the update. The change is visible from the next cycle.
- R11: When `up_valid` is low, no counter and no history bit changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken, same cycle |
| lk_hist | output | HIST_W | Current global history, carried with the branch |
| up_valid | input | 1 | A branch resolved this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_hist | input | HIST_W | History value used when this branch was predicted |

## Verification
Directed runs drive one branch address through saturation in both directions. They show the single-step hysteresis on the way out of a strong state and the flat response at each end. Alias probes vary only the low and high address bits, which checks that the index field is cut from the right bits. Updates made with an `up_hist` that differs from the live register tell apart a design that indexes with the supplied snapshot from one that uses the current register. A long pseudo-random phase mixes lookups, same-entry collisions and idle update inputs, and runs a plain-mode instance and a correlated-mode instance side by side against a model built from the requirements.

// File: rtl/bp_pkg.sv
package bp_pkg;

    localparam int IDX_LSB = 2;

    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_e;

    typedef enum logic {
        IDX_PLAIN    = 1'b0,
        IDX_XOR_HIST = 1'b1
    } idx_mode_e;

    function automatic ctr_e ctr_next(input ctr_e c, input logic taken);
        ctr_e n;
        unique case (c)
            CTR_SNT: n = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: n = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  n = taken ? CTR_ST  : CTR_WNT;
            default: n = taken ? CTR_ST  : CTR_WT;
        endcase
        return n;
    endfunction

    function automatic logic ctr_says_taken(input ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/dp_index.sv
module dp_index
    import bp_pkg::*;
#(
    parameter int        PC_W   = 32,
    parameter int        IDX_W  = 8,
    parameter int        HIST_W = 6,
    parameter idx_mode_e MODE   = IDX_XOR_HIST
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI = IDX_LSB + IDX_W;

    logic [IDX_W-1:0] field;
    assign field = pc[HI-1:IDX_LSB];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:HI], pc[IDX_LSB-1:0]};

    generate
        if (MODE == IDX_XOR_HIST) begin : g_xor
            assign idx = field ^ IDX_W'(hist);
        end else begin : g_plain
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = field;
        end
    endgenerate
endmodule

// File: rtl/dp_ghr.sv
module dp_ghr #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (shift_en) begin
            if (HIST_W > 1) hist <= {hist[HIST_W-2:0], shift_bit};
            else            hist <= HIST_W'(shift_bit);
        end
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(hist));

    assert_lsb_R8: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> hist[0] == $past(shift_bit));
endmodule

// File: rtl/dp_ctr_table.sv
module dp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ridx,
    output ctr_e             rdata,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic             wtaken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_e tbl [DEPTH];

    assign rdata = tbl[ridx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_WNT;
        end else if (we) begin
            tbl[widx] <= ctr_next(tbl[widx], wtaken);
        end
    end

    assert_sat_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (we && wtaken && tbl[widx] == CTR_ST) |=> tbl[$past(widx)] == CTR_ST);

    assert_sat_lo_R4: assert property (@(posedge clk) disable iff (rst)
        (we && !wtaken && tbl[widx] == CTR_SNT) |=> tbl[$past(widx)] == CTR_SNT);

    assert_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (we && !wtaken && tbl[widx] == CTR_ST) |=> tbl[$past(widx)] == CTR_WT);
endmodule

// File: rtl/dirpred.sv
module dirpred
    import bp_pkg::*;
#(
    parameter int        PC_W   = 32,
    parameter int        IDX_W  = 8,
    parameter int        HIST_W = 6,
    parameter idx_mode_e MODE   = IDX_XOR_HIST
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic [HIST_W-1:0] up_hist
);
    logic [HIST_W-1:0] ghr;
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    ctr_e              rd_ctr;

    dp_ghr #(.HIST_W(HIST_W)) u_ghr (
        .clk(clk), .rst(rst),
        .shift_en(up_valid), .shift_bit(up_taken),
        .hist(ghr)
    );

    dp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .MODE(MODE)) u_rd_idx (
        .pc(lk_pc), .hist(ghr), .idx(rd_idx)
    );

    dp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .MODE(MODE)) u_wr_idx (
        .pc(up_pc), .hist(up_hist), .idx(wr_idx)
    );

    dp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst(rst),
        .ridx(rd_idx), .rdata(rd_ctr),
        .we(up_valid), .widx(wr_idx), .wtaken(up_taken)
    );

    assign lk_taken = ctr_says_taken(rd_ctr);
    assign lk_hist  = ghr;
endmodule

// File: tb/tb_dirpred.sv
`timescale 1ns/1ps
module tb_dirpred;
    import bp_pkg::*;

    localparam int PC_W = 32, IDX_W = 8, HIST_W = 6, DEPTH = 256;

    logic clk = 1'b0, rst = 1'b1;
    logic [PC_W-1:0]   lk_pc = '0, up_pc = '0;
    logic              up_valid = 1'b0, up_taken = 1'b0;
    logic [HIST_W-1:0] up_hist = '0;
    logic              tk_x, tk_p;
    logic [HIST_W-1:0] hist_x, hist_p;

    always #2.5 clk = ~clk;

    dirpred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .MODE(IDX_XOR_HIST)) dut (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(tk_x), .lk_hist(hist_x),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

    dirpred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .MODE(IDX_PLAIN)) dut_plain (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(tk_p), .lk_hist(hist_p),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist));

    typedef struct {
        logic              px;
        logic              pp;
        logic [HIST_W-1:0] h;
        string             tag;
    } exp_t;

    exp_t q[$];
    int n_checks = 0, n_fail = 0;
    int mx[DEPTH], mp[DEPTH];
    logic [HIST_W-1:0] ghr_m;
    bit done = 0;

    function automatic int fld(input logic [PC_W-1:0] pc);
        return int'(pc[9:2]);
    endfunction

    function automatic int bump(input int c, input logic t);
        if (t) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    // Driver: applies one cycle of stimulus and pushes the expected outputs.
    task automatic step(input logic [PC_W-1:0] lpc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic ut,
                        input logic [HIST_W-1:0] uh, input string tag);
        exp_t e;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_hist = uh;
        e.px  = mx[fld(lpc) ^ int'(ghr_m)] >= 2;
        e.pp  = mp[fld(lpc)] >= 2;
        e.h   = ghr_m;
        e.tag = tag;
        q.push_back(e);
        if (uv) begin
            mx[fld(upc) ^ int'(uh)] = bump(mx[fld(upc) ^ int'(uh)], ut);
            mp[fld(upc)]            = bump(mp[fld(upc)], ut);
            ghr_m = {ghr_m[HIST_W-2:0], ut};
        end
    endtask

    // Monitor: compares each expected item shortly after it was driven.
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_checks += 3;
            if (tk_x !== e.px) begin
                n_fail++;
                $display("FAIL %s xor-mode pred act=%0b exp=%0b", e.tag, tk_x, e.px);
            end
            if (tk_p !== e.pp) begin
                n_fail++;
                $display("FAIL %s plain-mode pred act=%0b exp=%0b", e.tag, tk_p, e.pp);
            end
            if (hist_x !== e.h || hist_p !== e.h) begin
                n_fail++;
                $display("FAIL %s hist act=%h/%h exp=%h", e.tag, hist_x, hist_p, e.h);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [PC_W-1:0] PA = 32'h0000_0104;
    localparam logic [PC_W-1:0] PB = 32'h0000_0230;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mx[i] = 1; mp[i] = 1; end
        ghr_m = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of counters and history
        step(PA, 0, 0, 0, 0, "R1");
        step(PB, 0, 0, 0, 0, "R1");
        step(32'hFFFF_FFFC, 0, 0, 0, 0, "R1");

        // R2,R3: climb to strong taken and saturate
        for (int k = 0; k < 5; k++) step(PA, 1, PA, 1, 0, "R2,R3");
        step(PA, 0, 0, 0, 0, "R3");

        // R5: one miss from strong keeps taken, second flips
        step(PA, 1, PA, 0, 0, "R5");
        step(PA, 1, PA, 0, 0, "R5");
        step(PA, 0, 0, 0, 0, "R5");

        // R4: fall to strong not-taken and saturate
        for (int k = 0; k < 4; k++) step(PA, 1, PA, 0, 0, "R4");
        step(PA, 0, 0, 0, 0, "R4");

        // R6: aliases through ignored address bits
        for (int k = 0; k < 3; k++) step(PB, 1, PB, 1, 0, "R6");
        step(PB | 32'h0000_0400, 0, 0, 0, 0, "R6");
        step(PB | 32'h0000_0003, 0, 0, 0, 0, "R6");
        step(PB | 32'hABC0_0800, 0, 0, 0, 0, "R6");

        // R10: lookup and update of the same entry in one cycle
        step(PA, 1, PA, 1, 0, "R10");
        step(PA, 1, PA, 1, 0, "R10");
        step(PA, 0, 0, 0, 0, "R10");

        // R11: update inputs toggling with valid low
        for (int k = 0; k < 4; k++) step(PA, 0, PA, 1, 6'h2A, "R11");
        step(PB, 0, PB, 0, 6'h15, "R11");

        // R9: update snapshot differs from live history
        for (int k = 0; k < 3; k++) step(PA, 1, PA, 1, 6'h3F, "R9");
        for (int k = 0; k < 4; k++) step(PA ^ 32'h0000_00FC, 0, 0, 0, 0, "R9");

        // R8: known outcome pattern shifted into history
        step(PB, 1, PB, 1, 0, "R8");
        step(PB, 1, PB, 0, 0, "R8");
        step(PB, 1, PB, 1, 0, "R8");
        step(PB, 1, PB, 1, 0, "R8");
        step(PB, 0, 0, 0, 0, "R8");

        // R7: mixed pseudo-random traffic, realistic snapshots
        for (int k = 0; k < 600; k++) begin
            logic [PC_W-1:0] a;
            logic [PC_W-1:0] b;
            a = {$urandom} & 32'h0000_007C;
            b = (k % 5 == 0) ? a : ({$urandom} & 32'h0000_007C);
            step(a, ($urandom % 4) != 0, b, ($urandom % 3) != 0,
                 (k % 2 == 0) ? ghr_m : HIST_W'($urandom), "R7");
        end

        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule